// File: doc/BRIEF.md
# Bit-Sliced Vertical-Counter Switch Debouncer

This block cleans up a bank of mechanical switch inputs. It handles them in parallel. The raw pins first pass through a two-stage synchronizer. A prescaler then produces a sample strobe at a fixed interval, 5 ms by default. On each strobe every lane is captured into one snapshot register, so all switches are read at the same instant.

Each lane has a small down-counter. The counters are not stored per lane. Bit k of every counter sits in plane register k, so one bitwise expression per plane updates all lanes at once.

- When a lane's snapshot agrees with its debounced level, its counter is cleared.
- When the snapshot disagrees, the counter is decremented. It starts from zero, so the first decrement wraps it to all ones.
- When a decrement brings the counter back to zero, the new level is accepted.

With two planes this takes four disagreeing samples in a row, which is 15 ms from the first to the last at the default period. With three planes it takes eight. On each acceptance the block gives a one-clock pulse on that lane.

Top module: `vdebounce_vc`

## Requirements
- R1: While `rst_n` is low at a clock edge, `level_out` is loaded with the `RESET_STATE` parameter, `toggle_out` is cleared and every count plane is cleared.
- R2: A sample strobe occurs once every `SAMPLE_DIV` clocks, never on two adjacent clocks. At each strobe all lanes are captured from the output of the two-flop synchronizer.
- R3: A sample that equals a lane's debounced level clears that lane's counter. A disagreeing run of fewer than 2^PLANES samples, followed by an agreeing sample, never changes `level_out`, however often it repeats.
- R4: With PLANES=2, a lane's level flips after 4 consecutive disagreeing samples. `level_out` changes only on the clock edge that follows a strobe edge.
- R5: With PLANES=3, a lane's level flips only after 8 consecutive disagreeing samples. 4 or 5 such samples leave it unchanged.
- R6: `toggle_out[i]` is high for exactly one clock. It is high on the clock in which `level_out[i]` has just toggled, and it is low at every other time.
- R7: After a change is accepted, the lane's counter is zero. A return to the previous level needs a full new run of 2^PLANES disagreeing samples.
- R8: Lanes are independent. The counter and level of one lane are not affected by the activity of any other lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| raw_in | input | LANES | Raw asynchronous switch levels |
| level_out | output | LANES | Debounced switch levels |
| toggle_out | output | LANES | One-clock pulse per lane when its debounced level flips |

## Verification
The embedded assertions check the following on every clock:
- the strobe spacing,
- that lanes which matched or were just accepted leave the plane update with a zero counter,
- that the level only moves after a strobe,
- that each toggle pulse lasts exactly one clock and coincides with a level flip.

The required sample counts cannot be seen from any single cycle. These are the four samples for two planes, the eight for three, the restart after a short glitch, and the full recount after an acceptance. The bench shows them by timed scenarios on two instances, and by comparing both against a behavioural model during random bounce on every lane.

// File: rtl/vdb_pkg.sv
// Package vdb_pkg
// Shared helpers for the vertical-counter debouncer.
// Assumes: plane count is small (2 or 3), so 2**planes fits an int.
package vdb_pkg;

    // Number of consecutive disagreeing samples that confirm a change.
    function automatic int confirm_len(input int planes);
        return 1 << planes;
    endfunction

    // Width of a counter that must hold values 0 .. limit-1 (at least 1 bit).
    function automatic int cnt_width(input int limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/vdb_sync2.sv
// Module vdb_sync2
// Two-flop synchronizer for a vector of asynchronous levels.
// Assumes: each bit is an independent slow level; no bus coherence is required.
// The flops reset to RST_VAL so that no false mismatch is seen after reset.
module vdb_sync2 #(
    parameter int             W       = 8,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two-stage shift of the raw levels into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/vdb_tick_gen.sv
// Module vdb_tick_gen
// Prescaler that raises tick for one clock every DIV clocks.
// Assumes: DIV >= 2, so ticks are never adjacent.
module vdb_tick_gen #(
    parameter int DIV = 625000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    import vdb_pkg::*;
    localparam int CW = cnt_width(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    // Free-running modulo-DIV counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // R2: strobes are never on adjacent clocks.
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R2: the counter stays inside its modulo range.
    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/vdb_plane_bank.sv
// Module vdb_plane_bank
// Holds PLANES bit-planes. Plane k holds bit k of every lane's down-counter.
// When en is high, lanes in dec_mask are decremented by a bitwise borrow ripple
// across the planes, and all other lanes are cleared. hit marks the lanes whose
// decrement lands on zero. Such a lane's planes are then zero already, which is
// the clear that an accepted change requires.
// Assumes: PLANES is 2 or 3.
module vdb_plane_bank #(
    parameter int LANES  = 8,
    parameter int PLANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [LANES-1:0] dec_mask,
    output logic [LANES-1:0] hit,
    output logic [LANES-1:0] busy
);
    logic [LANES-1:0] plane_q   [PLANES];
    logic [LANES-1:0] plane_dec [PLANES];
    logic [LANES-1:0] borrow    [PLANES+1];
    logic [LANES-1:0] nz_chain  [PLANES+1];

    assign borrow[0]   = '1;
    assign nz_chain[0] = '0;

    // Per-plane decrement: bit flips where a borrow arrives, and the borrow
    // passes on where the bit was zero. For two planes this gives
    // low = ~low and high = high ^ ~low.
    for (genvar k = 0; k < PLANES; k++) begin : g_plane
        assign plane_dec[k]  = plane_q[k] ^ borrow[k];
        assign borrow[k+1]   = borrow[k] & ~plane_q[k];
        assign nz_chain[k+1] = nz_chain[k] | plane_dec[k];

        // Plane register: decremented value in the mask, cleared outside it.
        always_ff @(posedge clk) begin
            if (!rst_n)  plane_q[k] <= '0;
            else if (en) plane_q[k] <= plane_dec[k] & dec_mask;
        end
    end

    logic [LANES-1:0] any_q [PLANES+1];
    assign any_q[0] = '0;
    for (genvar k = 0; k < PLANES; k++) begin : g_any
        assign any_q[k+1] = any_q[k] | plane_q[k];
    end

    assign busy = any_q[PLANES];
    assign hit  = dec_mask & ~nz_chain[PLANES];

    // R3: after an update, every lane outside the mask has a zero counter.
    assert_clear_on_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ((busy & ~$past(dec_mask)) == '0));

    // R7: a lane that just hit zero leaves the update with a zero counter.
    assert_zero_after_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> ((busy & $past(hit)) == '0));

    // R8: the planes are held when no update is requested.
    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(busy));
endmodule

// File: rtl/vdebounce_vc.sv
// Module vdebounce_vc (top)
// Parallel switch debouncer. Raw pins -> two-flop synchronizer -> snapshot on
// each sample strobe -> on the next clock, a plane update over all lanes.
// A lane whose counter returns to zero flips its level and pulses toggle_out.
// Assumes: PLANES is 2 or 3; SAMPLE_DIV >= 2 (clock frequency times sample
// period; 625000 is 5 ms at 125 MHz).
module vdebounce_vc #(
    parameter int               LANES       = 8,
    parameter int               PLANES      = 2,
    parameter int               SAMPLE_DIV  = 625000,
    parameter logic [LANES-1:0] RESET_STATE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] raw_in,
    output logic [LANES-1:0] level_out,
    output logic [LANES-1:0] toggle_out
);
    logic [LANES-1:0] sync_q;
    logic [LANES-1:0] snap_q;
    logic             sample_tick;
    logic             upd_q;
    logic [LANES-1:0] mism;
    logic [LANES-1:0] hit;
    logic [LANES-1:0] busy;
    logic [LANES-1:0] level_q;
    logic [LANES-1:0] pulse_q;

    vdb_sync2 #(.W(LANES), .RST_VAL(RESET_STATE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_q)
    );

    vdb_tick_gen #(.DIV(SAMPLE_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (sample_tick)
    );

    // Snapshot register: all lanes are captured on the same strobe edge.
    always_ff @(posedge clk) begin
        if (!rst_n)           snap_q <= RESET_STATE;
        else if (sample_tick) snap_q <= sync_q;
    end

    // Update enable: one clock after each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= sample_tick;
    end

    assign mism = snap_q ^ level_q;

    vdb_plane_bank #(.LANES(LANES), .PLANES(PLANES)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (upd_q),
        .dec_mask (mism),
        .hit      (hit),
        .busy     (busy)
    );

    // Debounced level: flips the lanes whose counter reached zero.
    always_ff @(posedge clk) begin
        if (!rst_n)     level_q <= RESET_STATE;
        else if (upd_q) level_q <= level_q ^ hit;
    end

    // Change pulse: one clock, on the same edge as the level flip.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= '0;
        else        pulse_q <= upd_q ? hit : '0;
    end

    assign level_out  = level_q;
    assign toggle_out = pulse_q;

    // R4: the level moves only on the edge after a strobe.
    assert_level_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_q |=> $stable(level_q));

    // R6: a pulse never lasts two clocks.
    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_q != '0) |=> (pulse_q == '0));

    // R6: the pulse marks exactly the lanes whose level just toggled.
    assert_pulse_tracks_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q == (level_q ^ $past(level_q)));

    // R7: a lane that has just toggled starts from a cleared counter.
    assert_cleared_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy & pulse_q) == '0);
endmodule

// File: tb/vdebounce_vc_test.sv
// Behavioural reference: per-lane integer run counters. Compares each
// snapshot against the expected level and accepts after 2**PLANES runs.
module vdb_ref_model #(
    parameter int               LANES  = 4,
    parameter int               PLANES = 2,
    parameter int               DIV    = 4,
    parameter logic [LANES-1:0] RST    = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] raw,
    output logic [LANES-1:0] exp_level,
    output logic [LANES-1:0] exp_pulse
);
    localparam int NEED = 1 << PLANES;
    logic [LANES-1:0] pipe1, pipe2, shot;
    bit  due;
    int  phase;
    int  run [LANES];

    // One step of the model per clock, later stages first.
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_level = RST;
            exp_pulse = '0;
            pipe1 = RST; pipe2 = RST; shot = RST;
            due = 0; phase = 0;
            for (int i = 0; i < LANES; i++) run[i] = 0;
        end else begin
            exp_pulse = '0;
            if (due) begin
                for (int i = 0; i < LANES; i++) begin
                    if (shot[i] != exp_level[i]) begin
                        run[i] = run[i] + 1;
                        if (run[i] == NEED) begin
                            exp_level[i] = ~exp_level[i];
                            exp_pulse[i] = 1'b1;
                            run[i] = 0;
                        end
                    end else begin
                        run[i] = 0;
                    end
                end
            end
            due = (phase == DIV - 1);
            if (due) shot = pipe2;
            pipe2 = pipe1;
            pipe1 = raw;
            phase = (phase == DIV - 1) ? 0 : phase + 1;
        end
    end
endmodule

module vdebounce_vc_test;
    localparam int               LANES = 4;
    localparam int               DIV   = 4;
    localparam logic [LANES-1:0] RSTV  = 4'b0101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [LANES-1:0] raw = RSTV;
    logic [LANES-1:0] lvl2, tog2, lvl3, tog3;
    logic [LANES-1:0] el2, ep2, el3, ep3;

    int checks = 0;
    int errors = 0;
    bit cmp_on = 0;
    bit done = 0;
    int pulses2 = 0;
    int pulses3 = 0;

    always #4 clk = ~clk;   // 125 MHz

    vdebounce_vc #(.LANES(LANES), .PLANES(2), .SAMPLE_DIV(DIV), .RESET_STATE(RSTV)) uut (
        .clk(clk), .rst_n(rst_n), .raw_in(raw), .level_out(lvl2), .toggle_out(tog2));

    vdebounce_vc #(.LANES(LANES), .PLANES(3), .SAMPLE_DIV(DIV), .RESET_STATE(RSTV)) uut_p3 (
        .clk(clk), .rst_n(rst_n), .raw_in(raw), .level_out(lvl3), .toggle_out(tog3));

    vdb_ref_model #(.LANES(LANES), .PLANES(2), .DIV(DIV), .RST(RSTV)) ref2 (
        .clk(clk), .rst_n(rst_n), .raw(raw), .exp_level(el2), .exp_pulse(ep2));

    vdb_ref_model #(.LANES(LANES), .PLANES(3), .DIV(DIV), .RST(RSTV)) ref3 (
        .clk(clk), .rst_n(rst_n), .raw(raw), .exp_level(el3), .exp_pulse(ep3));

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Every-clock comparison against the model (R2 R4 R5 R6 R8).
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check(lvl2 == el2, "R4 level p2 vs model", lvl2, el2);
            check(tog2 == ep2, "R6 pulse p2 vs model", tog2, ep2);
            check(lvl3 == el3, "R5 level p3 vs model", lvl3, el3);
            check(tog3 == ep3, "R6 pulse p3 vs model", tog3, ep3);
            if (tog2[0]) pulses2++;
            if (tog3[0]) pulses3++;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        // R1: reset state.
        check(lvl2 == RSTV, "R1 reset level p2", lvl2, RSTV);
        check(tog2 == '0, "R1 reset pulse p2", tog2, 0);
        check(lvl3 == RSTV, "R1 reset level p3", lvl3, RSTV);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1;
        wait_clk(3 * DIV);

        // R3: two short glitches of 3 samples each on lane 0 never confirm.
        raw[0] = ~RSTV[0];
        wait_clk(3 * DIV);
        raw[0] = RSTV[0];
        wait_clk(3 * DIV);
        raw[0] = ~RSTV[0];
        wait_clk(3 * DIV);
        raw[0] = RSTV[0];
        wait_clk(4 * DIV);
        check(lvl2[0] == RSTV[0], "R3 glitch ignored p2", lvl2[0], RSTV[0]);
        check(lvl3[0] == RSTV[0], "R3 glitch ignored p3", lvl3[0], RSTV[0]);

        // R4 / R5: a held change confirms after 4 samples (p2), not yet (p3).
        raw[0] = ~RSTV[0];
        wait_clk(4 * DIV + 4);
        check(lvl2[0] == ~RSTV[0], "R4 change after 4 samples", lvl2[0], ~RSTV[0]);
        check(lvl3[0] == RSTV[0], "R5 not yet after 4-5 samples", lvl3[0], RSTV[0]);
        wait_clk(4 * DIV);
        check(lvl3[0] == ~RSTV[0], "R5 change after 8 samples", lvl3[0], ~RSTV[0]);
        check(pulses2 == 1, "R6 one pulse p2", pulses2, 1);
        check(pulses3 == 1, "R6 one pulse p3", pulses3, 1);

        // R7: returning needs a full new run.
        raw[0] = RSTV[0];
        wait_clk(3 * DIV + 1);
        check(lvl2[0] == ~RSTV[0], "R7 no early return", lvl2[0], ~RSTV[0]);
        wait_clk(DIV + 3);
        check(lvl2[0] == RSTV[0], "R7 return after full run", lvl2[0], RSTV[0]);

        // R8: lanes 1 and 2 step together while lane 3 chatters.
        raw[1] = ~RSTV[1];
        raw[2] = ~RSTV[2];
        for (int c = 0; c < 4 * DIV + 4; c++) begin
            raw[3] = ~raw[3];
            @(negedge clk);
        end
        raw[3] = RSTV[3];
        check(lvl2[2:1] == ~RSTV[2:1], "R8 lanes 1,2 changed", lvl2[2:1], ~RSTV[2:1]);
        check(lvl2[3] == RSTV[3], "R8 chattering lane 3 held", lvl2[3], RSTV[3]);

        // Random bounce with quiet stretches, checked against the model.
        for (int blk = 0; blk < 60; blk++) begin
            int len;
            bit noisy;
            len = 10 + $urandom_range(0, 60);
            noisy = $urandom_range(0, 1);
            for (int c = 0; c < len; c++) begin
                if (noisy) raw = raw ^ LANES'($urandom_range(0, 15));
                @(negedge clk);
            end
            if (!noisy) raw = LANES'($urandom_range(0, 15));
        end
        wait_clk(10 * DIV);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule